// File: doc/BRIEF.md
# Normalized Square QAM Mapper

This block maps each incoming symbol index to a point of a square QAM constellation. Build-time parameters choose the order (4, 16, 64 or 256 points) and whether the levels on each axis follow natural binary order or Gray order. The I and Q outputs are signed fixed-point values scaled so that the mean symbol power over the whole constellation equals one.

A symbol index arrives together with a valid strobe. The index is split into an in-phase half and a quadrature half. Each half is decoded to a position on its axis, and the position selects a rounded level from a small constant table that is computed when the design is built. The result is registered. Output valid follows input valid one cycle later, and the outputs hold their values while no new symbol arrives.

Top module: `qam_mapper`

## Requirements
- R1: Parameter `BITS_PER_SYM` takes the value 2, 4, 6 or 8, which gives 4, 16, 64 or 256 points. Any other value is rejected when the design is built.
- R2: The upper `BITS_PER_SYM/2` bits of `in_index` select the I level and the lower half selects the Q level.
- R3: With `GRAY_ORDER=0`, the axis position p is the axis bits read as an unsigned number. The unscaled level is 2p-(S-1), where S is the square root of the order. p=0 is the most negative level and adjacent levels are 2 apart.
- R4: With `GRAY_ORDER=1`, the axis position is the Gray-to-binary conversion of the axis bits. Bit k of the position is the XOR of the axis bits k and above. Levels that are neighbours on an axis therefore differ in exactly one bit.
- R5: Each output equals the unscaled level times 2^18 / sqrt(2(M-1)/3), rounded to the nearest integer. It is presented as a 20-bit two's-complement value with 18 fraction bits. A negative level gives the exact negation of the matching positive value.
- R6: Over all M indices, the mean of I²+Q² (scaled by 2^-36) lies within 1e-4 of 1.
- R7: `out_valid` equals `in_valid` from the previous rising clock edge. When `in_valid` was high, `out_i` and `out_q` hold the mapping of the index that was sampled with it.
- R8: While `in_valid` is low, `out_i` and `out_q` keep their values whatever `in_index` does.
- R9: While `rst_n` is low, `out_valid`, `out_i` and `out_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol index strobe |
| in_index | input | BITS_PER_SYM | Symbol index: I half above, Q half below |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_i | output | OUT_W (20) | In-phase level, signed, 18 fraction bits |
| out_q | output | OUT_W (20) | Quadrature level, signed, 18 fraction bits |

## Verification
The only state in the block is the output register and the valid flag, so any internal fault shows up at the ports in the cycle after the affected symbol. A wrong constant in the level table, a wrong split of the index or a wrong Gray decode gives a miscompare on the specific indices whose level it changes. A full sweep of every index in every order and ordering therefore exposes it within one pass. A stuck or mistimed valid flag, or outputs that load while the strobe is low, appear in the first cycle of a gap in the strobe.

// File: rtl/qam_pkg.sv
package qam_pkg;

   // Rounded magnitude of the positive level (2*lvl_idx+1) for an order-M square
   // constellation normalized to unit mean power, with frac fraction bits.
   function automatic int qam_mag(input int order, input int lvl_idx, input int frac);
      real scale;
      real r;
      scale = 1.0 / $sqrt(2.0 * real'(order - 1) / 3.0);
      r     = real'(2 * lvl_idx + 1) * scale * (2.0 ** frac);
      return $rtoi(r + 0.5);
   endfunction

   function automatic bit qam_bits_ok(input int bps);
      return (bps == 2) || (bps == 4) || (bps == 6) || (bps == 8);
   endfunction

endpackage

// File: rtl/qam_axis_decode.sv
module qam_axis_decode #(
   parameter int AXIS_W     = 2,
   parameter bit GRAY_ORDER = 1'b0
) (
   input  logic [AXIS_W-1:0] code,
   output logic [AXIS_W-1:0] pos
);

   generate
      if (GRAY_ORDER) begin : g_gray
         // prefix XOR from the MSB down
         for (genvar k = 0; k < AXIS_W; k++) begin : g_bit
            assign pos[k] = ^code[AXIS_W-1:k];
         end

         always_comb begin
            if (!$isunknown(code)) begin
               AST_GRAY_INVERSE: assert ((pos ^ (pos >> 1)) == code)
                  else $error("gray decode not inverse of encode"); // R4
            end
         end
      end else begin : g_bin
         assign pos = code;
      end
   endgenerate

endmodule

// File: rtl/qam_level_lut.sv
module qam_level_lut #(
   parameter int AXIS_W = 2,
   parameter int OUT_W  = 20,
   parameter int FRAC_W = 18
) (
   input  logic [AXIS_W-1:0] pos,
   output logic [OUT_W-1:0]  level
);

   localparam int ORDER = 1 << (2 * AXIS_W);
   localparam int HALF  = 1 << (AXIS_W - 1);
   localparam int IDX_W = (AXIS_W > 1) ? AXIS_W - 1 : 1;
   localparam int MAXV  = qam_pkg::qam_mag(ORDER, HALF - 1, FRAC_W);

   logic [OUT_W-1:0] mag [HALF];
   logic [IDX_W-1:0] lvl_idx;
   logic             upper;
   logic [OUT_W-1:0] sel;

   for (genvar i = 0; i < HALF; i++) begin : g_mag
      localparam int MV = qam_pkg::qam_mag(ORDER, i, FRAC_W);
      assign mag[i] = OUT_W'(MV);
   end

   assign upper = pos[AXIS_W-1];

   generate
      if (AXIS_W > 1) begin : g_multi
         // above the midpoint count outward, below it count inward
         assign lvl_idx = upper ? pos[AXIS_W-2:0] : ~pos[AXIS_W-2:0];
      end else begin : g_single
         assign lvl_idx = 1'b0;
      end
   endgenerate

   assign sel   = mag[lvl_idx];
   assign level = upper ? sel : (~sel + 1'b1);

   always_comb begin
      if (!$isunknown(pos)) begin
         AST_LEVEL_RANGE: assert (($signed(level) <= MAXV) && ($signed(level) >= -MAXV))
            else $error("level beyond normalized range"); // R5
         AST_LEVEL_SIGN: assert (($signed(level) > 0) == (int'(pos) >= HALF))
            else $error("level sign does not match axis half"); // R3
      end
   end

endmodule

// File: rtl/qam_mapper.sv
module qam_mapper #(
   parameter int BITS_PER_SYM = 4,
   parameter bit GRAY_ORDER   = 1'b0,
   parameter int OUT_W        = 20,
   parameter int INT_W        = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [BITS_PER_SYM-1:0] in_index,
   output logic                    out_valid,
   output logic [OUT_W-1:0]        out_i,
   output logic [OUT_W-1:0]        out_q
);

   localparam int AXIS_W = BITS_PER_SYM / 2;
   localparam int FRAC_W = OUT_W - INT_W;

   initial begin
      AST_ORDER_SUPPORTED: assert (qam_pkg::qam_bits_ok(BITS_PER_SYM))
         else $error("BITS_PER_SYM must be 2, 4, 6 or 8"); // R1
      AST_FORMAT_FITS: assert ((INT_W >= 2) && (OUT_W > INT_W))
         else $error("output format cannot hold unit-power levels"); // R5
   end

   logic [AXIS_W-1:0] pos_i, pos_q;
   logic [OUT_W-1:0]  lvl_i, lvl_q;

   qam_axis_decode #(.AXIS_W(AXIS_W), .GRAY_ORDER(GRAY_ORDER)) u_dec_i (
      .code (in_index[BITS_PER_SYM-1:AXIS_W]),
      .pos  (pos_i)
   );

   qam_axis_decode #(.AXIS_W(AXIS_W), .GRAY_ORDER(GRAY_ORDER)) u_dec_q (
      .code (in_index[AXIS_W-1:0]),
      .pos  (pos_q)
   );

   qam_level_lut #(.AXIS_W(AXIS_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_lut_i (
      .pos   (pos_i),
      .level (lvl_i)
   );

   qam_level_lut #(.AXIS_W(AXIS_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_lut_q (
      .pos   (pos_q),
      .level (lvl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_i <= lvl_i;
            out_q <= lvl_q;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid))
      else $error("output strobe not one cycle behind input strobe"); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> ($stable(out_i) && $stable(out_q)))
      else $error("outputs changed without a strobe"); // R8

endmodule

// File: tb/tb_qam_mapper.sv
`timescale 1ns/1ps
module tb_qam_mapper;

   localparam int NDUT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] idx = '0;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   // configuration per instance
   int  cfg_bps  [NDUT] = '{4, 4, 2, 6, 8, 8};
   bit  cfg_gray [NDUT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   logic        ov [NDUT];
   logic [19:0] oi [NDUT];
   logic [19:0] oq [NDUT];

   qam_mapper #(.BITS_PER_SYM(4), .GRAY_ORDER(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_index(idx[3:0]),
      .out_valid(ov[0]), .out_i(oi[0]), .out_q(oq[0]));
   qam_mapper #(.BITS_PER_SYM(4), .GRAY_ORDER(1'b1)) dut_g16 (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_index(idx[3:0]),
      .out_valid(ov[1]), .out_i(oi[1]), .out_q(oq[1]));
   qam_mapper #(.BITS_PER_SYM(2), .GRAY_ORDER(1'b0)) dut_b4 (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_index(idx[1:0]),
      .out_valid(ov[2]), .out_i(oi[2]), .out_q(oq[2]));
   qam_mapper #(.BITS_PER_SYM(6), .GRAY_ORDER(1'b1)) dut_g64 (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_index(idx[5:0]),
      .out_valid(ov[3]), .out_i(oi[3]), .out_q(oq[3]));
   qam_mapper #(.BITS_PER_SYM(8), .GRAY_ORDER(1'b0)) dut_b256 (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_index(idx),
      .out_valid(ov[4]), .out_i(oi[4]), .out_q(oq[4]));
   qam_mapper #(.BITS_PER_SYM(8), .GRAY_ORDER(1'b1)) dut_g256 (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_index(idx),
      .out_valid(ov[5]), .out_i(oi[5]), .out_q(oq[5]));

   // ---------------- reference model from the requirements ----------------
   function automatic int gray_to_bin(input int g, input int w);
      int r = 0;
      int prev = 0;
      for (int k = w - 1; k >= 0; k--) begin
         prev = prev ^ ((g >> k) & 1);
         r    = r | (prev << k);
      end
      return r;
   endfunction

   function automatic int exp_axis(input int bps, input bit gray, input int code);
      int  w    = bps / 2;
      int  s    = 1 << w;
      int  m    = 1 << bps;
      int  p    = gray ? gray_to_bin(code, w) : code;
      int  lvl  = 2 * p - (s - 1);
      int  al   = (lvl < 0) ? -lvl : lvl;
      real v    = real'(al) * (2.0 ** 18) / $sqrt(2.0 * real'(m - 1) / 3.0);
      int  mag  = $rtoi(v + 0.5);
      return (lvl < 0) ? -mag : mag;
   endfunction

   function automatic int sx20(input logic [19:0] v);
      return int'($signed(v));
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      for (int d = 0; d < NDUT; d++) begin
         check("R9", $sformatf("dut%0d valid in reset", d), int'(ov[d]), 0);
         check("R9", $sformatf("dut%0d I in reset", d), sx20(oi[d]), 0);
         check("R9", $sformatf("dut%0d Q in reset", d), sx20(oq[d]), 0);
      end
   endtask

   real pwr [NDUT];

   // full sweep: exact levels (R2..R5), latency (R7), orders (R1)
   task automatic t_sweep();
      for (int d = 0; d < NDUT; d++) pwr[d] = 0.0;
      for (int j = 0; j < 256; j++) begin
         idx = 8'(j);
         vld = 1'b1;
         @(negedge clk);
         for (int d = 0; d < NDUT; d++) begin
            int w  = cfg_bps[d] / 2;
            int c  = j & ((1 << cfg_bps[d]) - 1);
            int ci = c >> w;
            int cq = c & ((1 << w) - 1);
            int ei = exp_axis(cfg_bps[d], cfg_gray[d], ci);
            int eq = exp_axis(cfg_bps[d], cfg_gray[d], cq);
            string rq = cfg_gray[d] ? "R4" : "R3";
            check("R7", $sformatf("dut%0d valid idx %0d", d, j), int'(ov[d]), 1);
            check({rq, "/R5/R2/R1"}, $sformatf("dut%0d I idx %0d", d, j), sx20(oi[d]), ei);
            check({rq, "/R5/R2/R1"}, $sformatf("dut%0d Q idx %0d", d, j), sx20(oq[d]), eq);
            pwr[d] += real'(sx20(oi[d])) ** 2 + real'(sx20(oq[d])) ** 2;
         end
      end
   endtask

   // mean power over a full sweep: each order's indices repeat evenly in 256
   task automatic t_power();
      for (int d = 0; d < NDUT; d++) begin
         real mp = pwr[d] / 256.0 / (2.0 ** 36);
         real e  = mp - 1.0;
         n_vec++;
         if (e > 1.0e-4 || e < -1.0e-4) begin
            n_bad++;
            $display("FAIL R6 dut%0d mean power: actual %f expected 1.0 +/- 1e-4", d, mp);
         end
      end
   endtask

   // strobe low: outputs keep last mapping (index 255), valid drops (R8, R7)
   task automatic t_hold();
      vld = 1'b0;
      for (int n = 0; n < 4; n++) begin
         idx = 8'(17 * n + 3);
         @(negedge clk);
         for (int d = 0; d < NDUT; d++) begin
            int w  = cfg_bps[d] / 2;
            int m  = (1 << w) - 1;
            check("R7", $sformatf("dut%0d valid low", d), int'(ov[d]), 0);
            check("R8", $sformatf("dut%0d I held", d), sx20(oi[d]),
                  exp_axis(cfg_bps[d], cfg_gray[d], m));
            check("R8", $sformatf("dut%0d Q held", d), sx20(oq[d]),
                  exp_axis(cfg_bps[d], cfg_gray[d], m));
         end
      end
   endtask

   // single strobe then reset mid-run (R7, R9)
   task automatic t_pulse_reset();
      idx = 8'h00;
      vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
      check("R7", "dut index 0 I", sx20(oi[0]), exp_axis(4, 1'b0, 0));
      check("R7", "dut index 0 valid", int'(ov[0]), 1);
      @(negedge clk);
      check("R7", "dut valid after single pulse", int'(ov[0]), 0);
      rst_n = 1'b0;
      #1;
      for (int d = 0; d < NDUT; d++) begin
         check("R9", $sformatf("dut%0d I after reset", d), sx20(oi[d]), 0);
         check("R9", $sformatf("dut%0d Q after reset", d), sx20(oq[d]), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_sweep();
      t_power();
      t_hold();
      t_pulse_reset();
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule